// File: doc/BRIEF.md
# Signed Multiply-Accumulate Unit

This block is a multi-cycle execution unit for a 32-bit processor core. It multiplies two 16-bit two's-complement operands. In multiply-accumulate mode it also adds the product into a 42-bit accumulator. The pipeline hands it one command at a time over a valid/ready stream. Once a command is accepted, the core may keep issuing instructions that do not depend on the result. Completion appears as a valid/ready result stream that carries the 32-bit product.

The accumulator is 42 bits wide and wraps modulo 2^42, with no saturation. It is visible as two words:
- a low word holding bits 31:0;
- a high word that sign-extends bits 41:32 to 32 bits.

A read request is acknowledged only when no multiply is in flight, so a read never sees a partial result. A clear command zeroes the accumulator in one cycle. The clear is accepted only while the unit is idle.

Back-pressure rules:
- A command transfers on a cycle where `in_valid` and `in_ready` are both high.
- `in_ready` stays low from acceptance until the result has been taken.
- A result transfers on a cycle where `out_valid` and `out_ready` are both high.
- While `out_ready` is low, `out_valid` and `out_data` hold unchanged.

Top module: `mac_unit`

## Requirements
- R1: `in_ready` is high only when the unit is idle. At most one command is in flight, and `in_ready` stays low from the accepting edge until the result transfer edge.
- R2: With `in_op`=0 (multiply), `out_data` carries the signed 16x16 product as 32 bits, and the accumulator is left unchanged.
- R3: A multiply raises `out_valid` after exactly two rising edges following the edge that accepted it.
- R4: With `in_op`=1 (multiply-accumulate), `out_valid` rises after exactly three rising edges following the accepting edge.
- R5: A multiply-accumulate sign-extends the 32-bit product to 42 bits and adds it into the accumulator. The new value is visible when `out_valid` rises, and `out_data` also carries the product.
- R6: Accumulation wraps modulo 2^42 with no saturation.
- R7: `acc_lo` is accumulator bits 31:0. `acc_hi` is bits 41:32, sign-extended from bit 41 to 32 bits.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and a low `in_ready` are all held.
- R9: `rd_ack` equals `rd_req` except while a command is being computed, when it is low. It is high again in the result-waiting state.
- R10: `clr_ready` is high only when idle. A clear that is accepted zeroes both accumulator words on the next cycle. A clear offered while busy has no effect on the accumulator.
- R11: After reset, `in_ready` is 1, `out_valid` is 0 and the accumulator is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command valid |
| in_ready | output | 1 | Command can be accepted |
| in_op | input | 1 | 0 = multiply, 1 = multiply-accumulate |
| in_a | input | 16 | Signed operand A |
| in_b | input | 16 | Signed operand B |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result consumer ready |
| out_data | output | 32 | Signed product |
| rd_req | input | 1 | Accumulator read request |
| rd_ack | output | 1 | Accumulator words are final this cycle |
| acc_hi | output | 32 | Accumulator bits 41:32, sign-extended |
| acc_lo | output | 32 | Accumulator bits 31:0 |
| clr_valid | input | 1 | Clear request |
| clr_ready | output | 1 | Clear can be accepted |

## Verification
The assertions check the following on every cycle:
- the exact result latency of each operation type;
- that a stalled result holds still;
- that a read is never acknowledged mid-computation;
- that an accepted clear leaves zero behind;
- that the accumulator stays still when neither an add nor a clear is scheduled.

Only the bench's scenarios can show the arithmetic itself:
- correct signed products for the extreme operand values;
- sign-extended accumulation into the 42-bit register;
- the wrap past 2^42, reached through several thousand accumulations;
- that a clear offered mid-operation is really dropped.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_ACC  = 2'd2,
    ST_DONE = 2'd3
  } mac_state_e;

  typedef enum logic {
    OP_MUL = 1'b0,
    OP_MAC = 1'b1
  } mac_op_e;
endpackage

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_op,
  input  logic out_ready,
  input  logic clr_valid,
  output logic in_ready,
  output logic out_valid,
  output logic busy,
  output logic load_ops,
  output logic prod_en,
  output logic acc_en,
  output logic clr_en
);
  mac_state_e state_q, state_d;
  mac_op_e    op_q;

  assign in_ready  = (state_q == ST_IDLE);
  assign load_ops  = in_valid && in_ready;
  assign prod_en   = (state_q == ST_MUL);
  assign acc_en    = (state_q == ST_ACC);
  assign busy      = (state_q == ST_MUL) || (state_q == ST_ACC);
  assign out_valid = (state_q == ST_DONE);
  assign clr_en    = clr_valid && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (load_ops) state_d = ST_MUL;
      ST_MUL:  state_d = (op_q == OP_MAC) ? ST_ACC : ST_DONE;
      ST_ACC:  state_d = ST_DONE;
      ST_DONE: if (out_ready) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_MUL;
    end else begin
      state_q <= state_d;
      if (load_ops) op_q <= mac_op_e'(in_op);
    end
  end

  AST_MUL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ops && in_op == OP_MUL) |=> !out_valid ##1 out_valid); // R3
  AST_MAC_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (load_ops && in_op == OP_MAC) |=> !out_valid ##1 !out_valid ##1 out_valid); // R4
  AST_SINGLE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    load_ops |=> !in_ready); // R1
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
  parameter int OP_W = 16,
  localparam int PROD_W = 2 * OP_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [OP_W-1:0]   a,
  input  logic [OP_W-1:0]   b,
  input  logic              prod_en,
  output logic [PROD_W-1:0] prod
);
  logic signed [OP_W-1:0]   a_q, b_q;
  logic signed [PROD_W-1:0] prod_c;

  assign prod_c = a_q * b_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q  <= '0;
      b_q  <= '0;
      prod <= '0;
    end else begin
      if (load) begin
        a_q <= a;
        b_q <= b;
      end
      if (prod_en) prod <= prod_c;
    end
  end
endmodule

// File: rtl/mac_acc.sv
module mac_acc #(
  parameter int PROD_W = 32,
  parameter int ACC_W  = 42,
  localparam int EXT_W = ACC_W - PROD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add_en,
  input  logic [PROD_W-1:0] prod,
  output logic [ACC_W-1:0]  acc_q
);
  logic [ACC_W-1:0] prod_ext;

  assign prod_ext = {{EXT_W{prod[PROD_W-1]}}, prod};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (clr)    acc_q <= '0;
    else if (add_en) acc_q <= acc_q + prod_ext;
  end

  AST_ACC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !add_en) |=> $stable(acc_q)); // R2
endmodule

// File: rtl/mac_unit.sv
module mac_unit #(
  parameter int OP_W  = 16,
  parameter int ACC_W = 42,
  localparam int PROD_W = 2 * OP_W,
  localparam int HI_W   = ACC_W - PROD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_op,
  input  logic [OP_W-1:0]   in_a,
  input  logic [OP_W-1:0]   in_b,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PROD_W-1:0] out_data,
  input  logic              rd_req,
  output logic              rd_ack,
  output logic [PROD_W-1:0] acc_hi,
  output logic [PROD_W-1:0] acc_lo,
  input  logic              clr_valid,
  output logic              clr_ready
);
  logic             busy, load_ops, prod_en, acc_en, clr_en;
  logic [ACC_W-1:0] acc_q;

  mac_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_op    (in_op),
    .out_ready(out_ready),
    .clr_valid(clr_valid),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .busy     (busy),
    .load_ops (load_ops),
    .prod_en  (prod_en),
    .acc_en   (acc_en),
    .clr_en   (clr_en)
  );

  mac_mult #(.OP_W(OP_W)) u_mult (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (load_ops),
    .a      (in_a),
    .b      (in_b),
    .prod_en(prod_en),
    .prod   (out_data)
  );

  mac_acc #(.PROD_W(PROD_W), .ACC_W(ACC_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr_en),
    .add_en(acc_en),
    .prod  (out_data),
    .acc_q (acc_q)
  );

  assign clr_ready = in_ready;
  assign rd_ack    = rd_req && !busy;
  assign acc_lo    = acc_q[PROD_W-1:0];
  assign acc_hi    = {{(PROD_W-HI_W){acc_q[ACC_W-1]}}, acc_q[ACC_W-1:PROD_W]};

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && !in_ready)); // R8
  AST_CLR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_valid && clr_ready) |=> (acc_hi == '0 && acc_lo == '0)); // R10
  AST_RD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_ack) |-> (!in_ready && !out_valid)); // R9
endmodule

// File: tb/tb_mac_unit.sv
module tb_mac_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_op = 1'b0, out_ready = 1'b0;
  logic        rd_req = 1'b0, clr_valid = 1'b0;
  logic [15:0] in_a = '0, in_b = '0;
  logic        in_ready, out_valid, rd_ack, clr_ready;
  logic [31:0] out_data, acc_hi, acc_lo;

  int          n_checks = 0;
  int          n_fails  = 0;
  logic [41:0] m_acc    = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mac_unit dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_op(in_op),
    .in_a(in_a), .in_b(in_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .rd_req(rd_req), .rd_ack(rd_ack), .acc_hi(acc_hi), .acc_lo(acc_lo),
    .clr_valid(clr_valid), .clr_ready(clr_ready)
  );

  function automatic logic [31:0] exp_prod(logic [15:0] a, logic [15:0] b);
    int sa, sb;
    sa = int'($signed(a));
    sb = int'($signed(b));
    return 32'(sa * sb);
  endfunction

  function automatic logic [31:0] exp_hi(logic [41:0] acc);
    return {{22{acc[41]}}, acc[41:32]};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_acc(input string req);
    check(acc_lo == m_acc[31:0], req, 64'(acc_lo), 64'(m_acc[31:0]));
    check(acc_hi == exp_hi(m_acc), req, 64'(acc_hi), 64'(exp_hi(m_acc)));
  endtask

  task automatic do_op(input logic op, input logic [15:0] a, input logic [15:0] b,
                       input int hold);
    int          lat;
    logic [31:0] p;
    p = exp_prod(a, b);
    @(negedge clk);
    check(in_ready == 1'b1, "R1", 64'(in_ready), 64'd1);
    in_valid = 1'b1; in_op = op; in_a = a; in_b = b;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_a = $urandom; in_b = $urandom;
    lat = 1;
    check(in_ready == 1'b0, "R1", 64'(in_ready), 64'd0);
    rd_req = 1'b1; clr_valid = 1'b1;
    #1;
    check(rd_ack == 1'b0, "R9", 64'(rd_ack), 64'd0);
    check(clr_ready == 1'b0, "R10", 64'(clr_ready), 64'd0);
    @(negedge clk);
    rd_req = 1'b0; clr_valid = 1'b0;
    lat = 2;
    while (!out_valid && lat < 10) begin
      @(negedge clk);
      lat++;
    end
    if (op) begin
      check(lat == 3, "R4", 64'(lat), 64'd3);
      m_acc = m_acc + {{10{p[31]}}, p};
      check(out_data == p, "R5", 64'(out_data), 64'(p));
      check_acc("R5");
    end else begin
      check(lat == 2, "R3", 64'(lat), 64'd2);
      check(out_data == p, "R2", 64'(out_data), 64'(p));
      check_acc("R2");
    end
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check(out_valid && out_data == p && !in_ready, "R8", 64'(out_data), 64'(p));
    end
    rd_req = 1'b1;
    #1;
    check(rd_ack == 1'b1, "R9", 64'(rd_ack), 64'd1);
    rd_req = 1'b0;
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid && in_ready, "R1", 64'({out_valid, in_ready}), 64'b01);
    check_acc("R10");
  endtask

  task automatic do_clr();
    @(negedge clk);
    check(clr_ready == 1'b1, "R10", 64'(clr_ready), 64'd1);
    clr_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    clr_valid = 1'b0;
    m_acc = '0;
    check_acc("R10");
  endtask

  initial begin
    repeat (200000 - 10) @(posedge clk);
    n_fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R11", 64'(in_ready), 64'd1);
    check(out_valid == 1'b0, "R11", 64'(out_valid), 64'd0);
    check_acc("R11");

    do_op(1'b0, 16'h8000, 16'h8000, 0);
    do_op(1'b0, 16'h8000, 16'h7FFF, 2);
    do_op(1'b0, 16'hFFFF, 16'hFFFF, 0);
    do_op(1'b0, 16'h0000, 16'h1234, 1);
    do_op(1'b1, 16'hFFFF, 16'h0003, 0);
    check(acc_hi == 32'hFFFF_FFFF, "R7", 64'(acc_hi), 64'hFFFF_FFFF);
    do_op(1'b1, 16'h7FFF, 16'h7FFF, 3);
    do_clr();

    for (int i = 0; i < 60; i++)
      do_op(1'($urandom), 16'($urandom), 16'($urandom), int'($urandom % 3));
    do_clr();

    for (int i = 0; i < 4100; i++)
      do_op(1'b1, 16'h8000, 16'h8000, 0);
    check(acc_hi == 32'd1 && acc_lo == 32'd0, "R6",
          {acc_hi, acc_lo}, {32'd1, 32'd0});
    do_clr();

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule